// File: doc/BRIEF.md
# MSI-X Vector Table and Pending Array

This block holds the per-vector message table and the pending-bit array for a small set of message-signalled interrupt vectors. Software programs each entry through a memory-mapped slave port. Each entry has four 32-bit words: a low address, a high address, a payload word and a control word whose bit 0 masks the entry. Slave accesses may be 32 or 64 bits wide. A second window of the same 4 KB space shows the pending bits and is read-only.

Internal request lines `irq_in` set pending bits. A round-robin arbiter picks one pending, unmasked entry at a time. The block launches a single Dword memory-write request for that entry on a valid/ready master interface. It clears the pending bit when the request is accepted. A masked entry keeps its pending bit and sends nothing until software unmasks it.

Top module: `msix_vec_ctrl`

## Requirements
- R1: Entry K occupies bytes K*16 to K*16+15 of the window. On 32-bit accesses, byte offset 0 is the low address, 4 is the high address, 8 is the payload and 12 is the control word. Each word is readable and writable, and a 32-bit read returns the word on `acc_rdata[31:0]` with bits 63:32 zero.
- R2: A 64-bit access at entry offset 0 covers {high address, low address}. A 64-bit access at offset 8 covers {control, payload}. In both cases the lower-addressed word sits in bits 31:0.
- R3: After reset every address and payload word reads 0, and every control word reads 32'h1, so every entry starts masked.
- R4: Control bits 31:1 are stored as written and read back unchanged. Only bit 0 acts as the mask.
- R5: A 64-bit read at PBA_BASE + (K div 64)*8 returns pending bit K at bit K mod 64.
- R6: A 32-bit read at PBA_BASE + (K div 32)*4 returns pending bit K at bit K mod 32.
- R7: Writes to the pending window have no effect. Accesses outside the table (K >= NUM_VEC) and outside the pending window read 0, and writes there are ignored.
- R8: A request on a masked entry sets its pending bit and holds it, and no message is sent. Once the mask is cleared, the message goes out and the pending bit is cleared.
- R9: A request seen at clock edge N raises `msg_valid` after edge N+1. The message carries address {high, low}, data equal to the payload, and `msg_vec` equal to the entry index.
- R10: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr`, `msg_data` and `msg_vec` stay unchanged, even if software rewrites the entry.
- R11: The pending bit of the sent entry clears on the edge where `msg_valid && msg_ready`. If a new request for that same entry arrives on that same edge, the bit stays set and a further message follows.
- R12: When several entries are eligible, the search starts at the entry after the one last granted and wraps around. After reset the search starts at entry 0.
- R13: Read data appears on `acc_rdata` one clock after the access is presented and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_VEC | Interrupt requests, one per entry, sampled each edge |
| acc_valid | input | 1 | Slave access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| acc_addr | input | ADDR_W | Byte address within the 4 KB window |
| acc_wdata | input | 64 | Write data (32-bit writes use bits 31:0) |
| acc_rdata | output | 64 | Registered read data |
| msg_valid | output | 1 | Memory-write request pending |
| msg_ready | input | 1 | Request accepted by the downstream side |
| msg_addr | output | 64 | Target address of the Dword write |
| msg_data | output | 32 | Dword write data |
| msg_vec | output | IDX_W | Index of the entry being sent |

## Verification
Read data is due one edge after the access. The bench drives at a falling edge and samples at the next falling edge. An interrupt sampled at one edge becomes a pending bit after that edge and a raised `msg_valid` after the following edge. The bench therefore checks `msg_valid` low one falling edge after the request and high at the second. Pending-bit clearing and same-edge re-setting are checked by a window read started after the accepting edge. Arbitration order is taken from a monitor that logs each accepted request at falling edges.

// File: rtl/msix_pkg.sv
package msix_pkg;

    typedef struct packed {
        logic [31:0] ctrl;
        logic [31:0] data;
        logic [31:0] hi;
        logic [31:0] lo;
    } msix_ent_t;

    localparam msix_ent_t ENT_RST = '{ctrl: 32'h1, data: 32'h0, hi: 32'h0, lo: 32'h0};

endpackage

// File: rtl/msix_rr_arb.sv
module msix_rr_arb #(
    parameter int unsigned N    = 36,
    localparam int unsigned IW  = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          adv,
    output logic          gnt_valid,
    output logic [IW-1:0] gnt_idx
);
    typedef struct packed {
        logic [IW-1:0] ptr;
    } arb_st_t;

    arb_st_t      s_d, s_q;
    logic [N-1:0] gnt_oh;

    always_comb begin
        int unsigned c;
        s_d       = s_q;
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        gnt_oh    = '0;
        for (int unsigned i = 1; i <= N; i++) begin
            c = (int'(s_q.ptr) + i) % N;
            if (!gnt_valid && req[c]) begin
                gnt_valid = 1'b1;
                gnt_idx   = IW'(c);
                gnt_oh[c] = 1'b1;
            end
        end
        if (adv && gnt_valid) s_d.ptr = gnt_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q.ptr <= IW'(N - 1);
        else        s_q     <= s_d;
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_oh) && (gnt_valid == (req != '0))); // R12
    AST_GNT_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> ((gnt_oh & ~req) == '0)); // R12

endmodule

// File: rtl/msix_table.sv
module msix_table
    import msix_pkg::*;
#(
    parameter int unsigned NV       = 36,
    parameter int unsigned AW       = 12,
    parameter int unsigned PBA_BASE = 'h800,
    localparam int unsigned TAB_BYTES = NV * 16,
    localparam int unsigned PBA_QW    = (NV + 63) / 64,
    localparam int unsigned PBA_BITS  = PBA_QW * 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic                 acc_wide,
    input  logic [AW-1:0]        acc_addr,
    input  logic [63:0]          acc_wdata,
    input  logic [NV-1:0]        pend,
    output logic [63:0]          rdata,
    output msix_ent_t [NV-1:0]   ents
);
    typedef struct packed {
        msix_ent_t [NV-1:0] ent;
        logic [63:0]        rdata;
    } tab_st_t;

    tab_st_t             s_d, s_q;
    logic [PBA_BITS-1:0] pad;
    logic [63:0]         rd;

    always_comb begin
        int unsigned a, k, off, po;
        logic in_tab, in_pba;
        s_d    = s_q;
        pad    = '0;
        pad[NV-1:0] = pend;
        rd     = '0;
        a      = int'(acc_addr);
        k      = a / 16;
        off    = a % 16;
        po     = a - PBA_BASE;
        in_tab = a < TAB_BYTES;
        in_pba = (a >= PBA_BASE) && (a < PBA_BASE + PBA_QW * 8);

        if (in_tab) begin
            if (acc_wide) begin
                rd = (off >= 8) ? {s_q.ent[k].ctrl, s_q.ent[k].data}
                                : {s_q.ent[k].hi,   s_q.ent[k].lo};
            end else begin
                case (off / 4)
                    0:       rd = {32'h0, s_q.ent[k].lo};
                    1:       rd = {32'h0, s_q.ent[k].hi};
                    2:       rd = {32'h0, s_q.ent[k].data};
                    default: rd = {32'h0, s_q.ent[k].ctrl};
                endcase
            end
        end else if (in_pba) begin
            if (acc_wide) rd = pad[(po / 8) * 64 +: 64];
            else          rd = {32'h0, pad[(po / 4) * 32 +: 32]};
        end

        if (acc_valid) begin
            if (!acc_write) begin
                s_d.rdata = rd;
            end else if (in_tab) begin
                if (acc_wide) begin
                    if (off >= 8) begin
                        s_d.ent[k].data = acc_wdata[31:0];
                        s_d.ent[k].ctrl = acc_wdata[63:32];
                    end else begin
                        s_d.ent[k].lo   = acc_wdata[31:0];
                        s_d.ent[k].hi   = acc_wdata[63:32];
                    end
                end else begin
                    case (off / 4)
                        0:       s_d.ent[k].lo   = acc_wdata[31:0];
                        1:       s_d.ent[k].hi   = acc_wdata[31:0];
                        2:       s_d.ent[k].data = acc_wdata[31:0];
                        default: s_d.ent[k].ctrl = acc_wdata[31:0];
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(NV); i++) s_q.ent[i] <= ENT_RST;
            s_q.rdata <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata = s_q.rdata;
    assign ents  = s_q.ent;

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_write) |=> $stable(rdata)); // R13

endmodule

// File: rtl/msix_vec_ctrl.sv
module msix_vec_ctrl
    import msix_pkg::*;
#(
    parameter int unsigned NUM_VEC  = 36,
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned PBA_BASE = 'h800,
    localparam int unsigned IDX_W   = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] irq_in,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic               acc_wide,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic [63:0]        acc_wdata,
    output logic [63:0]        acc_rdata,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data,
    output logic [IDX_W-1:0]   msg_vec
);
    typedef struct packed {
        logic [NUM_VEC-1:0] pend;
        logic               busy;
        logic [63:0]        addr;
        logic [31:0]        data;
        logic [IDX_W-1:0]   vec;
    } ctl_st_t;

    ctl_st_t                 s_d, s_q;
    msix_ent_t [NUM_VEC-1:0] ents;
    logic [NUM_VEC-1:0]      eligible;
    logic                    gnt_valid;
    logic [IDX_W-1:0]        gnt_idx;
    logic                    launch;

    msix_table #(.NV(NUM_VEC), .AW(ADDR_W), .PBA_BASE(PBA_BASE)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_wide  (acc_wide),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .pend      (s_q.pend),
        .rdata     (acc_rdata),
        .ents      (ents)
    );

    msix_rr_arb #(.N(NUM_VEC)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (eligible),
        .adv       (launch),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx)
    );

    always_comb begin
        for (int i = 0; i < int'(NUM_VEC); i++)
            eligible[i] = s_q.pend[i] & ~ents[i].ctrl[0];
    end

    always_comb begin
        s_d    = s_q;
        launch = 1'b0;
        if (s_q.busy && msg_ready) begin
            s_d.busy          = 1'b0;
            s_d.pend[s_q.vec] = 1'b0;
        end
        s_d.pend = s_d.pend | irq_in;
        if (!s_q.busy && gnt_valid) begin
            launch   = 1'b1;
            s_d.busy = 1'b1;
            s_d.addr = {ents[gnt_idx].hi, ents[gnt_idx].lo};
            s_d.data = ents[gnt_idx].data;
            s_d.vec  = gnt_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign msg_valid = s_q.busy;
    assign msg_addr  = s_q.addr;
    assign msg_data  = s_q.data;
    assign msg_vec   = s_q.vec;

    AST_MSG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr)
                                       && $stable(msg_data) && $stable(msg_vec))); // R10
    AST_LAUNCH_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> ((($past(eligible) >> msg_vec) & NUM_VEC'(1)) != '0)); // R8
    AST_IRQ_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_in != '0) |=> ((s_q.pend & $past(irq_in)) == $past(irq_in))); // R11
    AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready && !irq_in[msg_vec]) |=> !s_q.pend[$past(msg_vec)]); // R11

endmodule

// File: tb/tb_msix_vec_ctrl.sv
module tb_msix_vec_ctrl;
    localparam int NV = 36;
    localparam int IW = $clog2(NV);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NV-1:0] irq_in = '0;
    logic          acc_valid = 1'b0, acc_write = 1'b0, acc_wide = 1'b0;
    logic [11:0]   acc_addr = '0;
    logic [63:0]   acc_wdata = '0;
    logic [63:0]   acc_rdata;
    logic          msg_valid, msg_ready = 1'b1;
    logic [63:0]   msg_addr;
    logic [31:0]   msg_data;
    logic [IW-1:0] msg_vec;

    int nchk = 0, nfail = 0, ncol = 0;
    bit done = 1'b0;
    logic [IW-1:0] got_vec  [32];
    logic [63:0]   got_addr [32];
    logic [31:0]   got_data [32];

    always #10 clk = ~clk;

    msix_vec_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_wide(acc_wide),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
        .msg_data(msg_data), .msg_vec(msg_vec)
    );

    always @(negedge clk) begin
        if (rst_n && msg_valid && msg_ready && ncol < 32) begin
            got_vec[ncol]  = msg_vec;
            got_addr[ncol] = msg_addr;
            got_data[ncol] = msg_data;
            ncol++;
        end
    end

    // {tag, write, wide, addr, wdata, expected}
    localparam int NVEC = 17;
    localparam logic [173:0] VEC [NVEC] = '{
        {"R3  ", 1'b0, 1'b0, 12'h00C, 64'h0, 64'h1},
        {"R3  ", 1'b0, 1'b0, 12'h018, 64'h0, 64'h0},
        {"R1  ", 1'b1, 1'b0, 12'h010, 64'hA000_1000, 64'h0},
        {"R1  ", 1'b0, 1'b0, 12'h010, 64'h0, 64'hA000_1000},
        {"R1  ", 1'b1, 1'b0, 12'h234, 64'h1234_5678, 64'h0},
        {"R1  ", 1'b0, 1'b0, 12'h234, 64'h0, 64'h1234_5678},
        {"R2  ", 1'b1, 1'b1, 12'h020, 64'h0000_0001_FEE0_0040, 64'h0},
        {"R2  ", 1'b0, 1'b0, 12'h024, 64'h0, 64'h1},
        {"R2  ", 1'b0, 1'b1, 12'h020, 64'h0, 64'h0000_0001_FEE0_0040},
        {"R2  ", 1'b1, 1'b1, 12'h028, 64'h0000_0001_0000_00AB, 64'h0},
        {"R4  ", 1'b1, 1'b0, 12'h03C, 64'hDEAD_BEE0, 64'h0},
        {"R4  ", 1'b0, 1'b0, 12'h03C, 64'h0, 64'hDEAD_BEE0},
        {"R7  ", 1'b1, 1'b1, 12'h800, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
        {"R7  ", 1'b0, 1'b1, 12'h800, 64'h0, 64'h0},
        {"R7  ", 1'b1, 1'b0, 12'h240, 64'h5555_5555, 64'h0},
        {"R7  ", 1'b0, 1'b0, 12'h240, 64'h0, 64'h0},
        {"R7  ", 1'b0, 1'b0, 12'h400, 64'h0, 64'h0}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the capturing edge.
    task automatic acc(input logic w, input logic wide, input logic [11:0] a, input logic [63:0] wd);
        acc_valid = 1'b1; acc_write = w; acc_wide = wide; acc_addr = a; acc_wdata = wd;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic pulse_irq(input logic [NV-1:0] m);
        irq_in = m;
        @(negedge clk);
        irq_in = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3", {63'h0, msg_valid}, 64'h0);

        for (int i = 0; i < NVEC; i++) begin
            logic [173:0] v;
            v = VEC[i];
            acc(v[141], v[140], v[139:128], v[127:64]);
            if (!v[141]) check(string'(v[173:142]), acc_rdata, v[63:0]);
        end

        // R13: read data held while no read is presented
        acc(1'b0, 1'b0, 12'h010, 64'h0);
        repeat (2) @(negedge clk);
        check("R13", acc_rdata, 64'hA000_1000);

        // R8 / R5 / R6: masked entries 6 and 33 keep pending bits
        acc(1'b1, 1'b0, 12'h060, 64'hFEE0_0600);
        acc(1'b1, 1'b0, 12'h068, 64'h66);
        pulse_irq((NV'(1) << 6) | (NV'(1) << 33));
        repeat (4) @(negedge clk);
        check("R8", {63'h0, msg_valid}, 64'h0);
        acc(1'b0, 1'b1, 12'h800, 64'h0);
        check("R5", acc_rdata, 64'h0000_0002_0000_0040);
        acc(1'b0, 1'b0, 12'h804, 64'h0);
        check("R6", acc_rdata, 64'h2);
        acc(1'b0, 1'b0, 12'h800, 64'h0);
        check("R6", acc_rdata, 64'h40);
        acc(1'b1, 1'b0, 12'h804, 64'h0);
        acc(1'b0, 1'b0, 12'h804, 64'h0);
        check("R7", acc_rdata, 64'h2);
        base = ncol;
        acc(1'b1, 1'b0, 12'h06C, 64'h0);
        repeat (4) @(negedge clk);
        check("R8", 64'(ncol - base), 64'h1);
        check("R9", got_addr[base], 64'h0000_0000_FEE0_0600);
        check("R9", {32'h0, got_data[base]}, 64'h66);
        check("R9", 64'(got_vec[base]), 64'd6);
        acc(1'b0, 1'b1, 12'h800, 64'h0);
        check("R8", acc_rdata, 64'h0000_0002_0000_0000);

        // R9 latency on entry 2, R12 rotation with entries 1 and 3
        acc(1'b1, 1'b0, 12'h01C, 64'h0);
        acc(1'b1, 1'b0, 12'h02C, 64'h0);
        irq_in = NV'(1) << 2;
        @(negedge clk);
        irq_in = '0;
        check("R9", {63'h0, msg_valid}, 64'h0);
        @(negedge clk);
        check("R9", {63'h0, msg_valid}, 64'h1);
        check("R9", 64'(msg_vec), 64'd2);
        check("R9", {32'h0, msg_data}, 64'hAB);
        repeat (3) @(negedge clk);
        base = ncol;
        pulse_irq((NV'(1) << 1) | (NV'(1) << 3));
        repeat (8) @(negedge clk);
        check("R12", 64'(ncol - base), 64'd2);
        check("R12", 64'(got_vec[base]), 64'd3);
        check("R12", 64'(got_vec[base + 1]), 64'd1);
        check("R12", got_addr[base + 1], 64'hA000_1000);

        // R10: stall with entry 4, rewrite its payload while waiting
        msg_ready = 1'b0;
        acc(1'b1, 1'b0, 12'h048, 64'h44);
        acc(1'b1, 1'b0, 12'h04C, 64'h0);
        pulse_irq(NV'(1) << 4);
        @(negedge clk);
        check("R10", {63'h0, msg_valid}, 64'h1);
        acc(1'b1, 1'b0, 12'h048, 64'h99);
        repeat (3) @(negedge clk);
        check("R10", {63'h0, msg_valid}, 64'h1);
        check("R10", {32'h0, msg_data}, 64'h44);
        check("R10", 64'(msg_vec), 64'd4);

        // R11: accept and new request for entry 4 on the same edge
        msg_ready = 1'b1;
        irq_in    = NV'(1) << 4;
        @(negedge clk);
        msg_ready = 1'b0;
        irq_in    = '0;
        acc(1'b0, 1'b0, 12'h800, 64'h0);
        check("R11", acc_rdata, 64'h10);
        check("R11", {63'h0, msg_valid}, 64'h1);
        check("R11", {32'h0, msg_data}, 64'h99);
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
        acc(1'b0, 1'b0, 12'h800, 64'h0);
        check("R11", acc_rdata, 64'h0);
        check("R11", {63'h0, msg_valid}, 64'h0);

        finish_run();
    end
endmodule